// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus side of a byte-addressed 32K x 8 serial memory. It watches the two-wire bus with the system clock and finds the framing conditions. It then receives a select byte, two address bytes and any number of data bytes, and can also stream stored bytes back to the master. The bus data line is open-drain. The block never drives a high level; it asserts `sda_oe` to pull the line low.

Each accepted data byte is passed to the storage array as a single write strobe that carries an address and a byte. A separate commit block owns the nonvolatile programming. This engine gives it a one-cycle `commit_o` pulse when a write transaction closes correctly. While that block reports busy, the engine does not answer its select byte, so a master can poll until the memory is free. Reads take the byte that the array shows combinationally at `mem_addr`.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset the slave releases SDA and is idle. A START (SDA falling while SCL is high) restarts select-byte reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the slave to idle.
- R2: The first byte after START is taken MSB first and is acknowledged (SDA held low during the 9th clock) only if its upper seven bits equal 1010, then 0, then `chip_pins[1]`, then `chip_pins[0]`. Bit 0 selects the direction, with 1 meaning read.
- R3: If the select byte does not match, no acknowledge is given and every later byte is ignored, without acknowledge, until the next START.
- R4: After a write select, two address bytes are acknowledged, high byte first. Bit 7 of the high byte (address bit 15) is discarded, which gives a 15-bit memory address.
- R5: Each acknowledged data byte produces one `mem_we` pulse that carries its address on `mem_addr` and the byte on `mem_wdata`.
- R6: Within one write transaction only address bits [5:0] advance after each data byte. Bits [14:6] stay fixed, so writing past the end of a 64-byte row continues at the start of that row.
- R7: While `wr_lock` is high, the select and address bytes are still acknowledged, but each data byte gets no acknowledge and produces no `mem_we`.
- R8: `commit_o` pulses once when a STOP arrives right after the acknowledge slot of a data byte, and only if at least one byte was written since the START. A STOP at any other point gives no pulse.
- R9: A random read is a write select followed by two address bytes, then a repeated START with a read select. The first byte returned is the one stored at that address.
- R10: In a read, the address pointer advances by one after each byte is loaded and wraps from 0x7FFF to 0x0000. A read select with no address phase continues from the pointer.
- R11: After each read byte the slave samples the master's acknowledge in the 9th clock. On a NOACK it stops driving SDA until the next START.
- R12: While `busy_i` is high, a matching select byte is not acknowledged.
- R13: `sda_oe` only becomes active while the synchronized SCL is low, so the driven level holds for the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| chip_pins | input | 2 | Strapped chip-enable value compared against select bits [2:1] |
| wr_lock | input | 1 | Write protect; data bytes are refused while high |
| busy_i | input | 1 | Commit block busy; select bytes are refused while high |
| mem_addr | output | ADDR_W | Array address for reads and write strobes |
| mem_rdata | input | 8 | Array data at `mem_addr` (combinational) |
| mem_wdata | output | 8 | Write data byte |
| mem_we | output | 1 | One-cycle write strobe |
| commit_o | output | 1 | One-cycle request to program the written bytes |

## Verification
The STOP detector and the commit decision act in the same cycle. Whether `commit_o` fires depends on where the bit counter stood when the STOP was seen. The bench provokes this by closing one write transaction with a STOP right after the data acknowledge, and another with a single extra clocked bit before the STOP. It judges the result by counting commit pulses against the expected count, while the scoreboard still accounts for the write strobe of each byte. A second collision is the row wrap on the final byte of a page write. Here the address step and the write strobe of the next byte must land in the same row, which the scoreboard checks address by address.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DEV  = 3'd1,
    S_AHI  = 3'd2,
    S_ALO  = 3'd3,
    S_WDAT = 3'd4,
    S_RDAT = 3'd5
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Upper seven bits of a select byte against the strapped pins.
  function automatic logic sel_match(input logic [7:0] b, input logic [1:0] pins);
    return b[7:1] == {DEV_TYPE, 1'b0, pins};
  endfunction

endpackage

// File: rtl/ee_i2c_line_sampler.sv
module ee_i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/ee_i2c_shifter.sv
module ee_i2c_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         cap_bit,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         adv_en,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (adv_en) begin
      q <= {q[W-2:0], 1'b1};
    end else if (cap_en) begin
      q <= {q[W-2:0], cap_bit};
    end
  end

endmodule

// File: rtl/ee_i2c_addr_ctr.sv
module ee_i2c_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [7:0]        byte_in,
  input  logic              page_step,
  input  logic              seq_step,
  output logic [ADDR_W-1:0] addr
);

  localparam int HI_W = ADDR_W - 8;

  // Step inside a row: upper bits held, column wraps.
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], PAGE_W'(a[PAGE_W-1:0] + 1'b1)};
  endfunction

  // Step through the whole array with wrap to zero.
  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + 1'b1);
  endfunction

  logic [HI_W-1:0] hi_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
      addr    <= '0;
    end else begin
      if (hi_we) hi_hold <= byte_in[HI_W-1:0];
      if (lo_we)          addr <= {hi_hold, byte_in};
      else if (page_step) addr <= page_next(addr);
      else if (seq_step)  addr <= seq_next(addr);
    end
  end

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        chip_pins,
  input  logic              wr_lock,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              commit_o
);
  import ee_i2c_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;
  localparam logic [3:0] STOP_POS = 4'd1;

  // Named internal events (also used by the checker).
  logic scl_lvl_w, sda_lvl_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic sel_ok_w, in_sel_w, rx_w, decide_w, slot_end_w;

  phase_t      st;
  logic [3:0]  bcnt;
  logic        ack_drv, tx_drv, rd_mode, mack, wrote, dirty;
  logic [7:0]  shreg;
  logic        sh_cap, sh_load, sh_adv, hi_we, lo_we, page_step;

  ee_i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl_w), .sda_lvl(sda_lvl_w),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w)
  );

  assign rx_w       = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_WDAT);
  assign in_sel_w   = (st == S_DEV);
  assign sel_ok_w   = sel_match(shreg, chip_pins);
  assign decide_w   = scl_fall_w && rx_w && (bcnt == LAST_BIT);
  assign slot_end_w = scl_fall_w && (bcnt == ACK_BIT);

  assign sh_cap    = scl_rise_w && rx_w && (bcnt < LAST_BIT);
  assign sh_adv    = scl_fall_w && (st == S_RDAT) && (bcnt != 4'd0) && (bcnt < LAST_BIT);
  assign sh_load   = slot_end_w && (((st == S_DEV) && rd_mode) || ((st == S_RDAT) && mack));
  assign hi_we     = decide_w && (st == S_AHI);
  assign lo_we     = decide_w && (st == S_ALO);
  assign page_step = slot_end_w && (st == S_WDAT) && wrote;

  ee_i2c_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cap_en(sh_cap), .cap_bit(sda_lvl_w),
    .load_en(sh_load), .load_val(mem_rdata),
    .adv_en(sh_adv), .q(shreg)
  );

  ee_i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .hi_we(hi_we), .lo_we(lo_we), .byte_in(shreg),
    .page_step(page_step), .seq_step(sh_load),
    .addr(mem_addr)
  );

  // Wired-AND output: pull low for ACK or for a transmitted zero.
  assign sda_oe = ack_drv | (tx_drv & ~shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o <= 1'b0;
    end else begin
      commit_o <= stop_w && (st == S_WDAT) && (bcnt == STOP_POS) && dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bcnt      <= '0;
      ack_drv   <= 1'b0;
      tx_drv    <= 1'b0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      wrote     <= 1'b0;
      dirty     <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_w) begin
        st      <= S_DEV;
        bcnt    <= '0;
        ack_drv <= 1'b0;
        tx_drv  <= 1'b0;
        dirty   <= 1'b0;
      end else if (stop_w) begin
        st      <= S_IDLE;
        ack_drv <= 1'b0;
        tx_drv  <= 1'b0;
      end else begin
        if (scl_rise_w && (st != S_IDLE) && (bcnt < LAST_BIT)) bcnt <= bcnt + 4'd1;
        if (scl_rise_w && (st == S_RDAT) && (bcnt == ACK_BIT)) mack <= ~sda_lvl_w;
        if (decide_w) begin
          bcnt <= ACK_BIT;
          unique case (st)
            S_DEV: begin
              if (!busy_i && sel_ok_w) begin
                ack_drv <= 1'b1;
                rd_mode <= shreg[0];
              end else begin
                st <= S_IDLE;
              end
            end
            S_AHI, S_ALO: ack_drv <= 1'b1;
            S_WDAT: begin
              if (!wr_lock) begin
                ack_drv   <= 1'b1;
                mem_we    <= 1'b1;
                mem_wdata <= shreg;
                dirty     <= 1'b1;
                wrote     <= 1'b1;
              end else begin
                wrote <= 1'b0;
              end
            end
            default: ;
          endcase
        end else if (slot_end_w && rx_w) begin
          ack_drv <= 1'b0;
          bcnt    <= '0;
          unique case (st)
            S_DEV: begin
              if (rd_mode) begin
                st     <= S_RDAT;
                tx_drv <= 1'b1;
              end else begin
                st <= S_AHI;
              end
            end
            S_AHI:   st <= S_ALO;
            S_ALO:   st <= S_WDAT;
            default: st <= S_WDAT;
          endcase
        end else if (scl_fall_w && (st == S_RDAT)) begin
          if (bcnt == LAST_BIT) begin
            tx_drv <= 1'b0;
            bcnt   <= ACK_BIT;
          end else if (bcnt == ACK_BIT) begin
            if (mack) begin
              tx_drv <= 1'b1;
              bcnt   <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              commit,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_lock,
  input logic              busy,
  input logic              sel_ok,
  input logic              in_select
);

  logic              seen;
  logic [ADDR_W-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last <= '0;
    end else if (start_evt) begin
      seen <= 1'b0;
    end else if (mem_we) begin
      seen <= 1'b1;
      last <= mem_addr;
    end
  end

  // R13
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R8
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_evt));

  // R7
  lock_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!wr_lock));

  // R12
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && in_select) |-> $past(!busy && sel_ok));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && seen) |-> ((mem_addr[ADDR_W-1:PAGE_W] == last[ADDR_W-1:PAGE_W]) &&
                          (mem_addr[PAGE_W-1:0] == PAGE_W'(last[PAGE_W-1:0] + 1'b1))));

endmodule

bind ee_i2c_slave ee_i2c_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl_w),
  .start_evt(start_w), .stop_evt(stop_w), .commit(commit_o),
  .mem_we(mem_we), .mem_addr(mem_addr), .wr_lock(wr_lock), .busy(busy_i),
  .sel_ok(sel_ok_w), .in_select(in_sel_w)
);

// File: tb/ee_i2c_slave_bench.sv
module ee_i2c_slave_bench;

  localparam int Q = 5;
  localparam logic [7:0] SEL_W = 8'hA2;  // 1010 0 01 0
  localparam logic [7:0] SEL_R = 8'hA3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] chip_pins = 2'b01;
  logic wr_lock = 1'b0, busy_i = 1'b0;
  logic sda_oe, mem_we, commit_o;
  logic [14:0] mem_addr;
  logic [7:0] mem_rdata = 8'hFF, mem_wdata;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  ee_i2c_slave u_ee_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .chip_pins(chip_pins), .wr_lock(wr_lock), .busy_i(busy_i),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .commit_o(commit_o)
  );

  int checks = 0, fails = 0, commits = 0;
  logic [7:0] store [int];
  logic [7:0] refm  [int];
  logic [22:0] exp_wr [$];
  string       exp_tag [$];
  logic [14:0] cur_ptr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_rd(input logic [14:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 8'hFF;
  endfunction

  // Storage model and write monitor (scoreboard consumer).
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        store[int'(mem_addr)] = mem_wdata;
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [22:0] e;
          string t;
          e = exp_wr.pop_front();
          t = exp_tag.pop_front();
          chk({mem_addr, mem_wdata} == e, t, {mem_addr, mem_wdata}, e);
        end
      end
      if (commit_o) commits++;
      mem_rdata = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'hFF;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    logic early;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(1); early = sda_line; tick(Q-1);
    b = sda_line; tick(Q-1);
    chk(early == b && sda_line == b, "R13 SDA stable while SCL high", sda_line, b);
    tick(1); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  // Write transaction without the closing STOP; expectations pushed first.
  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input bit exp_ack, input string req);
    logic ack;
    logic [7:0] d;
    logic [14:0] wa;
    i2c_start();
    send_byte(SEL_W, ack); chk(ack, "R2 write select acked", ack, 1);
    send_byte(a[15:8], ack); chk(ack, "R4 high address acked", ack, 1);
    send_byte(a[7:0], ack);  chk(ack, "R4 low address acked", ack, 1);
    for (int i = 0; i < n; i++) begin
      d  = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : d3;
      wa = {a[14:6], 6'(a[5:0] + i[5:0])};
      if (exp_ack) begin
        exp_wr.push_back({wa, d});
        exp_tag.push_back(req);
        refm[int'(wa)] = d;
      end
      send_byte(d, ack);
      chk(ack == exp_ack, req, ack, exp_ack);
    end
  endtask

  task automatic read_stream(input int n, input string req);
    logic [7:0] d;
    logic [7:0] e;
    for (int i = 0; i < n; i++) begin
      e = ref_rd(cur_ptr);
      recv_byte(d, i < n - 1);
      chk(d == e, req, d, e);
      cur_ptr = 15'(cur_ptr + 1'b1);
    end
  endtask

  task automatic do_rand_read(input logic [15:0] a, input int n, input string req);
    logic ack;
    i2c_start();
    send_byte(SEL_W, ack);   chk(ack, "R9 dummy write select acked", ack, 1);
    send_byte(a[15:8], ack); chk(ack, "R9 high address acked", ack, 1);
    send_byte(a[7:0], ack);  chk(ack, "R9 low address acked", ack, 1);
    i2c_start();
    send_byte(SEL_R, ack);   chk(ack, "R9 read select acked", ack, 1);
    cur_ptr = a[14:0];
    read_stream(n, req);
    i2c_stop();
  endtask

  task automatic expect_commits(input int want, input string req);
    tick(10);
    chk(commits == want, req, commits, want);
  endtask

  bit done = 1'b0;

  initial begin
    logic ack;
    logic b;
    int base;
    tick(4);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && commit_o == 1'b0, "R1 reset idle", {sda_oe, mem_we, commit_o}, 0);
    rst_n = 1'b1;
    tick(4);

    // Byte write then commit on STOP right after ACK.
    do_write(16'h0123, 1, 8'h5A, 0, 0, 0, 1'b1, "R5 byte write");
    i2c_stop();
    expect_commits(1, "R8 commit after byte write");

    do_rand_read(16'h0123, 1, "R9 random read value");

    // Page write past the row end.
    do_write(16'h0C3E, 4, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1, "R6 row wrap write");
    i2c_stop();
    expect_commits(2, "R8 commit after page write");
    chk(exp_wr.size() == 0, "R6 all page bytes written", exp_wr.size(), 0);

    do_rand_read(16'h0C3E, 2, "R10 sequential read");
    i2c_start();
    send_byte(SEL_R, ack); chk(ack, "R10 current read select acked", ack, 1);
    read_stream(1, "R10 current address read");
    i2c_stop();
    do_rand_read(16'h0C00, 2, "R6 wrapped bytes at row start");

    // Bit 15 discarded.
    do_write(16'h8005, 1, 8'h77, 0, 0, 0, 1'b1, "R4 bit15 ignored write");
    i2c_stop();
    do_rand_read(16'h0005, 1, "R4 bit15 ignored readback");

    // Array wrap on read.
    do_write(16'h7FFF, 1, 8'hAB, 0, 0, 0, 1'b1, "R5 top address write");
    i2c_stop();
    do_write(16'h0000, 1, 8'hCD, 0, 0, 0, 1'b1, "R5 zero address write");
    i2c_stop();
    do_rand_read(16'h7FFF, 3, "R10 wrap to zero");

    // Select mismatch.
    i2c_start();
    send_byte(8'hA0, ack); chk(!ack, "R3 wrong chip pins no ack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3 following byte ignored", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hAA, ack); chk(!ack, "R2 fixed bit must be zero", ack, 0);
    i2c_stop();

    // Write lock.
    base = commits;
    wr_lock = 1'b1;
    do_write(16'h0123, 2, 8'h99, 8'h98, 0, 0, 1'b0, "R7 locked data no ack");
    i2c_stop();
    wr_lock = 1'b0;
    expect_commits(base, "R8 no commit without written byte");
    do_rand_read(16'h0123, 1, "R7 locked location unchanged");

    // Busy commit block.
    busy_i = 1'b1;
    i2c_start();
    send_byte(SEL_W, ack); chk(!ack, "R12 busy select refused", ack, 0);
    i2c_stop();
    busy_i = 1'b0;
    i2c_start();
    send_byte(SEL_W, ack); chk(ack, "R12 select acked once free", ack, 1);
    i2c_stop();

    // NOACK releases the line.
    do_rand_read(16'h0123, 1, "R9 read before release test");
    i2c_start();
    send_byte(SEL_R, ack); chk(ack, "R11 read select acked", ack, 1);
    read_stream(1, "R11 byte before noack");
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      chk(b == 1'b1, "R11 line released after noack", b, 1);
    end
    i2c_stop();

    // START inside a byte restarts reception.
    i2c_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_start();
    send_byte(SEL_W, ack); chk(ack, "R1 restart mid byte", ack, 1);
    i2c_stop();

    // STOP one bit late: write strobe yes, commit no.
    base = commits;
    do_write(16'h0200, 1, 8'h42, 0, 0, 0, 1'b1, "R5 late stop write");
    send_bit(1'b0);
    i2c_stop();
    expect_commits(base, "R8 late stop no commit");
    chk(exp_wr.size() == 0, "R5 scoreboard drained", exp_wr.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule